// File: doc/BRIEF.md
# Sideband Error Signaling Controller

This block turns classified error events into two active-low sideband outputs. The first is `fatal_n`, a bus-initialization request for serious errors. The second is `intr_n`, a level interrupt for milder ones. Error sources present one-hot or multi-hot vectors in three classes: fatal, system-error and interrupt. Each bit may be a single-cycle pulse or a held level. A separate `hard_fail` qualifier marks the current cycle's events as coming from a hard-fail completion, and such events are dropped.

The fatal path is a four-state machine over the pair {override, fatal-asserted}:
- `F_HELD` (override set, pin idle) is the reset state.
- `F_FIRED` (override set, pin driven) is entered when a qualifying event arrives while the override is clear. The override arms itself in the same edge.
- `F_ARMED` (override clear, pin idle).
- `F_LIVE` (override clear, pin still driven).

Transitions:
- A qualifying event moves ARMED→FIRED and LIVE→FIRED.
- A write-1-to-clear of the fatal status bit moves FIRED→HELD and LIVE→ARMED.
- A control write of override=0 moves FIRED→LIVE and HELD→ARMED.
- A control write of override=1 moves ARMED→HELD and LIVE→FIRED.

The interrupt path is a three-state machine:
- `I_QUIET`: no status bit and no records.
- `I_RAISED`: the interrupt status bit is set.
- `I_PENDING`: the status bit is cleared but records remain.

Transitions:
- Any record-setting event goes to RAISED.
- From RAISED, a status write-1-to-clear goes to PENDING if records remain, otherwise to QUIET.
- PENDING goes to QUIET once the last record is cleared.

Software reaches the block through a single-cycle register port:
- Address 0 is status: bit0 is fatal asserted and bit1 is interrupt asserted. Both bits are write-1-to-clear.
- Address 1 is control: bit0 is override, bit1 is escalate and bit2 is route-all. All three are read/write.
- Address 2 holds the records: bit i is interrupt source i and bit `NUM_INTR` is the routed record. All bits are write-1-to-clear.
- Address 3 reads zero.

Reads are combinational from `reg_addr`.

Top module: `sbe_sig_ctl`

## Requirements
- R1: After reset `fatal_n` and `intr_n` are 1, control reads 3'b001 (override set, escalate and route-all clear), and status and records read 0.
- R2: A fatal-class event while override is 0 drives `fatal_n` low one clock later, and sets status bit0 and control bit0 in that same edge.
- R3: While override is 1, no event drives `fatal_n` low or sets status bit0.
- R4: Writing 1 to status bit0 returns `fatal_n` to 1 on the next clock and leaves override unchanged.
- R5: Software can write override to 1, which disables fatal signaling, or to 0, which re-arms it. The value used for firing is the one held before the write.
- R6: A system-error-class event reaches `fatal_n` only when escalate (control bit1) was 1 before the event.
- R7: An interrupt-class event on source i sets record bit i and status bit1, and drives `intr_n` low one clock later.
- R8: `intr_n` is low exactly while status bit1 or any record bit is set. Clearing status bit1 alone keeps it low while records remain.
- R9: With route-all (control bit2) set, any fatal-class or system-error-class event sets record bit `NUM_INTR` and status bit1.
- R10: In a cycle with `hard_fail` high, no event of any class changes a status bit, a record bit or a sideband output.
- R11: When an event and a write-1-to-clear hit the same bit in the same cycle, the bit ends set.
- R12: Reads return status, control and records as mapped above, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-good reset |
| err_fatal | input | NUM_FATAL | Fatal-class error events |
| err_serr | input | NUM_SERR | System-error-class error events |
| err_intr | input | NUM_INTR | Interrupt-class error events |
| hard_fail | input | 1 | Marks this cycle's events as hard-fail completions, which are dropped |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NUM_INTR+1 | Write data |
| reg_rdata | output | NUM_INTR+1 | Read data for `reg_addr` |
| fatal_n | output | 1 | Active-low fatal bus-initialization output |
| intr_n | output | 1 | Active-low level interrupt output |

## Verification
The bench drives a second fatal event while already fired. It expects no new status change, whereas a design without the self-arming override would re-fire once software cleared status. It clears interrupt status while a record is still held, where a design lacking the pending hold would drop `intr_n` early. It also races an event against a write-1-to-clear and an override write in the same cycle. A design that lets the write win, or that fires from the newly written override, would leave a bit clear or assert `fatal_n` a cycle early. Hard-fail cycles carrying every error class check that nothing leaks through the qualifier. Escalation is probed with the enable both off and on.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
    localparam logic [1:0] ADDR_STS = 2'd0;
    localparam logic [1:0] ADDR_CTL = 2'd1;
    localparam logic [1:0] ADDR_REC = 2'd2;

    // fatal path state, encoded as {override, asserted}
    typedef enum logic [1:0] {
        F_ARMED = 2'b00,
        F_LIVE  = 2'b01,
        F_HELD  = 2'b10,
        F_FIRED = 2'b11
    } fatal_st_t;

    typedef enum logic [1:0] {
        I_QUIET   = 2'd0,
        I_RAISED  = 2'd1,
        I_PENDING = 2'd2
    } intr_st_t;
endpackage

// File: rtl/sbe_fatal_fsm.sv
module sbe_fatal_fsm
    import sbe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    input  logic sts_clr,
    input  logic ovr_wr,
    input  logic ovr_wval,
    output logic ovr,
    output logic sts
);
    fatal_st_t st_q, st_d;
    logic      n_ovr, n_sts;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_HELD;
        else        st_q <= st_d;
    end

    always_comb begin
        n_ovr = 1'b1;
        n_sts = 1'b0;
        unique case (st_q)
            F_ARMED: begin
                n_ovr = ovr_wr ? ovr_wval : 1'b0;
                n_sts = 1'b0;
                if (fire_req) begin
                    n_ovr = 1'b1;
                    n_sts = 1'b1;
                end
            end
            F_LIVE: begin
                n_ovr = ovr_wr ? ovr_wval : 1'b0;
                n_sts = !sts_clr;
                if (fire_req) begin
                    n_ovr = 1'b1;
                    n_sts = 1'b1;
                end
            end
            F_HELD: begin
                n_ovr = ovr_wr ? ovr_wval : 1'b1;
                n_sts = 1'b0;
            end
            F_FIRED: begin
                n_ovr = ovr_wr ? ovr_wval : 1'b1;
                n_sts = !sts_clr;
            end
            default: begin
                n_ovr = 1'b1;
                n_sts = 1'b0;
            end
        endcase
        st_d = fatal_st_t'({n_ovr, n_sts});
    end

    always_comb begin
        ovr = st_q[1];
        sts = st_q[0];
    end
endmodule

// File: rtl/sbe_intr_track.sv
module sbe_intr_track
    import sbe_pkg::*;
#(
    parameter int NUM_INTR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_INTR:0] set_rec,
    input  logic [NUM_INTR:0] clr_rec,
    input  logic              sts_clr,
    output logic [NUM_INTR:0] rec,
    output logic              sts,
    output logic              intr_n
);
    intr_st_t          st_q, st_d;
    logic [NUM_INTR:0] rec_q, rec_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= I_QUIET;
            rec_q <= '0;
        end else begin
            st_q  <= st_d;
            rec_q <= rec_d;
        end
    end

    always_comb begin
        rec_d = (rec_q & ~clr_rec) | set_rec;
        st_d  = st_q;
        if (|set_rec) begin
            st_d = I_RAISED;
        end else begin
            unique case (st_q)
                I_RAISED:  if (sts_clr) st_d = (|rec_d) ? I_PENDING : I_QUIET;
                I_PENDING: st_d = (|rec_d) ? I_PENDING : I_QUIET;
                I_QUIET:   st_d = (|rec_d) ? I_PENDING : I_QUIET;
                default:   st_d = I_QUIET;
            endcase
        end
    end

    always_comb begin
        rec    = rec_q;
        sts    = (st_q == I_RAISED);
        intr_n = (st_q == I_QUIET);
    end
endmodule

// File: rtl/sbe_cfg_reg.sv
module sbe_cfg_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wval,
    output logic       esc,
    output logic       route
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esc   <= 1'b0;
            route <= 1'b0;
        end else if (wr) begin
            esc   <= wval[0];
            route <= wval[1];
        end
    end
endmodule

// File: rtl/sbe_sig_ctl.sv
module sbe_sig_ctl
    import sbe_pkg::*;
#(
    parameter int NUM_FATAL = 4,
    parameter int NUM_SERR  = 4,
    parameter int NUM_INTR  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FATAL-1:0] err_fatal,
    input  logic [NUM_SERR-1:0]  err_serr,
    input  logic [NUM_INTR-1:0]  err_intr,
    input  logic                 hard_fail,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [NUM_INTR:0]    reg_wdata,
    output logic [NUM_INTR:0]    reg_rdata,
    output logic                 fatal_n,
    output logic                 intr_n
);
    localparam int DW = NUM_INTR + 1;

    logic          ovr_q, fsts_q, esc_q, route_q, ists_q;
    logic          wr_sts, wr_ctl, wr_rec, fire_req, any_harsh;
    logic [DW-1:0] set_rec, clr_rec, rec_q;

    always_comb begin
        wr_sts    = reg_wr && (reg_addr == ADDR_STS);
        wr_ctl    = reg_wr && (reg_addr == ADDR_CTL);
        wr_rec    = reg_wr && (reg_addr == ADDR_REC);
        any_harsh = (|err_fatal) || (|err_serr);
        fire_req  = !hard_fail && ((|err_fatal) || (esc_q && (|err_serr)));
        set_rec   = hard_fail ? '0 : {route_q && any_harsh, err_intr};
        clr_rec   = wr_rec ? reg_wdata : '0;
    end

    sbe_fatal_fsm u_fatal (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_req (fire_req),
        .sts_clr  (wr_sts && reg_wdata[0]),
        .ovr_wr   (wr_ctl),
        .ovr_wval (reg_wdata[0]),
        .ovr      (ovr_q),
        .sts      (fsts_q)
    );

    sbe_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ctl),
        .wval  (reg_wdata[2:1]),
        .esc   (esc_q),
        .route (route_q)
    );

    sbe_intr_track #(.NUM_INTR(NUM_INTR)) u_intr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_rec (set_rec),
        .clr_rec (clr_rec),
        .sts_clr (wr_sts && reg_wdata[1]),
        .rec     (rec_q),
        .sts     (ists_q),
        .intr_n  (intr_n)
    );

    always_comb begin
        fatal_n   = !fsts_q;
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STS: reg_rdata[1:0] = {ists_q, fsts_q};
            ADDR_CTL: reg_rdata[2:0] = {route_q, esc_q, ovr_q};
            ADDR_REC: reg_rdata      = rec_q;
            default:  reg_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/sbe_sig_chk.sv
module sbe_sig_chk #(
    parameter int NUM_FATAL = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fatal_n,
    input logic                 intr_n,
    input logic                 ovr,
    input logic                 esc,
    input logic                 reg_wr,
    input logic                 hard_fail,
    input logic [NUM_FATAL-1:0] err_fatal
);
    // R2: the fatal pin only falls together with the override arming
    p_fire_arms_ovr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fatal_n) |-> ovr);

    // R3: override set with pin idle keeps the pin idle
    p_no_refire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && fatal_n) |=> fatal_n);

    // R4: the fatal pin is only released by a software write
    p_fatal_release_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_n) |-> $past(reg_wr));

    // R6: without escalation, system-error events cannot reach the fatal pin
    p_escalate_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!esc && (err_fatal == '0) && fatal_n) |=> fatal_n);

    // R8: the interrupt only releases after a software write
    p_intr_release_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_n) |-> $past(reg_wr));

    // R10: hard-fail cycles cannot raise either output
    p_hard_fail_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_fail && fatal_n && intr_n) |=> (fatal_n && intr_n));
endmodule

bind sbe_sig_ctl sbe_sig_chk #(.NUM_FATAL(NUM_FATAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fatal_n   (fatal_n),
    .intr_n    (intr_n),
    .ovr       (ovr_q),
    .esc       (esc_q),
    .reg_wr    (reg_wr),
    .hard_fail (hard_fail),
    .err_fatal (err_fatal)
);

// File: tb/sbe_sig_ctl_tb.sv
module sbe_sig_ctl_tb;
    localparam int NF = 4;
    localparam int NS = 4;
    localparam int NI = 7;
    localparam int DW = NI + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] err_fatal = '0;
    logic [NS-1:0] err_serr = '0;
    logic [NI-1:0] err_intr = '0;
    logic          hard_fail = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          fatal_n, intr_n;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference state
    logic m_ovr, m_fsts, m_esc, m_route, m_ists;
    logic [DW-1:0] m_rec;

    sbe_sig_ctl #(.NUM_FATAL(NF), .NUM_SERR(NS), .NUM_INTR(NI)) u_dut (
        .clk(clk), .rst_n(rst_n), .err_fatal(err_fatal), .err_serr(err_serr),
        .err_intr(err_intr), .hard_fail(hard_fail), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fatal_n(fatal_n), .intr_n(intr_n)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] rd_model(input logic [1:0] a);
        logic [DW-1:0] v;
        v = '0;
        case (a)
            2'd0: v[1:0] = {m_ists, m_fsts};
            2'd1: v[2:0] = {m_route, m_esc, m_ovr};
            2'd2: v = m_rec;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_update();
        logic fire, harsh;
        logic [DW-1:0] setv;
        harsh = (|err_fatal) || (|err_serr);
        fire  = !hard_fail && ((|err_fatal) || (m_esc && (|err_serr))) && !m_ovr;
        setv  = hard_fail ? '0 : {m_route && harsh, err_intr};
        m_fsts = fire || (m_fsts && !(reg_wr && reg_addr == 2'd0 && reg_wdata[0]));
        m_ists = (|setv) || (m_ists && !(reg_wr && reg_addr == 2'd0 && reg_wdata[1]));
        m_rec  = (m_rec & ~((reg_wr && reg_addr == 2'd2) ? reg_wdata : '0)) | setv;
        if (reg_wr && reg_addr == 2'd1) begin
            m_esc   = reg_wdata[1];
            m_route = reg_wdata[2];
        end
        m_ovr = fire ? 1'b1 : ((reg_wr && reg_addr == 2'd1) ? reg_wdata[0] : m_ovr);
    endtask

    task automatic step(input logic [NF-1:0] f, input logic [NS-1:0] s,
                        input logic [NI-1:0] i, input logic hf, input logic wr,
                        input logic [1:0] a, input logic [DW-1:0] wd);
        err_fatal = f; err_serr = s; err_intr = i; hard_fail = hf;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        model_update();
        @(negedge clk);
        err_fatal = '0; err_serr = '0; err_intr = '0; hard_fail = 1'b0; reg_wr = 1'b0;
        check(cur_req, "fatal_n", DW'(fatal_n), DW'(!m_fsts));
        check(cur_req, "intr_n", DW'(intr_n), DW'(!(m_ists || (|m_rec))));
        check(cur_req, "rdata", reg_rdata, rd_model(a));
    endtask

    task automatic idle(); step('0, '0, '0, 1'b0, 1'b0, 2'd0, '0); endtask
    task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
        step('0, '0, '0, 1'b0, 1'b1, a, d);
    endtask
    task automatic peek(input logic [1:0] a, input logic [DW-1:0] exp);
        reg_addr = a;
        #1;
        check(cur_req, "read", reg_rdata, exp);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EB1);
        m_ovr = 1'b1; m_fsts = 1'b0; m_esc = 1'b0; m_route = 1'b0;
        m_ists = 1'b0; m_rec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        check("R1", "fatal_n reset", DW'(fatal_n), DW'(1'b1));
        check("R1", "intr_n reset", DW'(intr_n), DW'(1'b1));
        peek(2'd0, '0);
        peek(2'd1, DW'(3'b001));
        peek(2'd2, '0);
        cur_req = "R12";
        peek(2'd3, '0);

        cur_req = "R3";
        step(4'b0010, '0, '0, 1'b0, 1'b0, 2'd0, '0);
        check("R3", "fatal blocked at reset", DW'(fatal_n), DW'(1'b1));

        cur_req = "R5";
        wreg(2'd1, DW'(3'b000));
        peek(2'd1, '0);
        cur_req = "R2";
        step(4'b0001, '0, '0, 1'b0, 1'b0, 2'd1, '0);
        check("R2", "fatal fires", DW'(fatal_n), DW'(1'b0));
        check("R2", "override armed", reg_rdata, DW'(3'b001));
        cur_req = "R3";
        step(4'b1000, '0, '0, 1'b0, 1'b0, 2'd0, '0);
        cur_req = "R4";
        wreg(2'd0, DW'(2'b01));
        check("R4", "fatal released", DW'(fatal_n), DW'(1'b1));
        peek(2'd1, DW'(3'b001));
        cur_req = "R3";
        step(4'b0100, '0, '0, 1'b0, 1'b0, 2'd0, '0);
        check("R3", "no refire", DW'(fatal_n), DW'(1'b1));

        cur_req = "R6";
        wreg(2'd1, DW'(3'b000));
        step('0, 4'b0100, '0, 1'b0, 1'b0, 2'd0, '0);
        check("R6", "serr without escalate", DW'(fatal_n), DW'(1'b1));
        wreg(2'd1, DW'(3'b010));
        step('0, 4'b0001, '0, 1'b0, 1'b0, 2'd0, '0);
        check("R6", "serr escalated", DW'(fatal_n), DW'(1'b0));
        wreg(2'd0, DW'(2'b01));

        cur_req = "R7";
        step('0, '0, 7'b0000100, 1'b0, 1'b0, 2'd2, '0);
        check("R7", "record bit2", reg_rdata, DW'(8'h04));
        check("R7", "intr low", DW'(intr_n), DW'(1'b0));
        cur_req = "R8";
        wreg(2'd0, DW'(2'b10));
        check("R8", "held by record", DW'(intr_n), DW'(1'b0));
        wreg(2'd2, DW'(8'h04));
        check("R8", "released", DW'(intr_n), DW'(1'b1));

        cur_req = "R9";
        wreg(2'd1, DW'(3'b100));
        step('0, 4'b0010, '0, 1'b0, 1'b0, 2'd2, '0);
        check("R9", "routed record", reg_rdata, DW'(8'h80));
        wreg(2'd2, DW'(8'h80));
        wreg(2'd0, DW'(2'b11));

        cur_req = "R10";
        wreg(2'd1, DW'(3'b110));
        step(4'b1111, 4'b1111, 7'h7F, 1'b1, 1'b0, 2'd0, '0);
        check("R10", "hard fail status", reg_rdata, '0);
        check("R10", "hard fail pins", DW'({fatal_n, intr_n}), DW'(2'b11));
        peek(2'd2, '0);

        cur_req = "R11";
        step(4'b0001, '0, '0, 1'b0, 1'b1, 2'd0, DW'(2'b01));
        check("R11", "fire beats clear", DW'(fatal_n), DW'(1'b0));
        step('0, '0, 7'b0000001, 1'b0, 1'b1, 2'd2, DW'(8'h01));
        check("R11", "record set beats clear", reg_rdata, DW'(8'h81));
        cur_req = "R5";
        step(4'b0001, '0, '0, 1'b0, 1'b1, 2'd1, DW'(3'b000));
        peek(2'd1, '0);

        cur_req = "R12";
        for (int k = 0; k < 3000; k++) begin
            logic [NF-1:0] f;
            logic [NS-1:0] s;
            logic [NI-1:0] iv;
            logic wr;
            f  = ($urandom % 12 == 0) ? NF'(1 << ($urandom % NF)) : '0;
            s  = ($urandom % 12 == 0) ? NS'(1 << ($urandom % NS)) : '0;
            iv = ($urandom % 8 == 0) ? NI'($urandom) : '0;
            wr = ($urandom % 6 == 0);
            step(f, s, iv, ($urandom % 10 == 0), wr, 2'($urandom), DW'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule